// File: doc/BRIEF.md
# Merging Write Store Buffer with Line Completion

This block sits between a processor write port and the cache and memory behind it. Each write carries a line address, a security bit, a cacheable write-allocate attribute and a full-line data word qualified by a byte strobe. The block keeps a small set of slots. A write is folded into a slot already held for the same line and security bit while that slot is still collecting. Otherwise it opens a new slot. Slots are retired one at a time, oldest first.

Retiring a slot depends on its attribute. A slot without write-allocate goes straight to memory as a masked write and skips the cache. A write-allocate slot is first looked up in the cache. On a hit its written bytes are stored into the cache. On a miss with every byte written, the line is allocated at once. On a miss with gaps, the block reads the line from memory, fills only the bytes the processor left untouched, and then allocates the completed line.

The cache and memory sinks accept a request in the cycle it is presented. The cache answers a lookup in the same cycle. Read data may come back any number of cycles after the request.

Top module: `wr_merge_buf`

## Requirements
- R1: A write merges into an occupied slot only when both its line address and its security bit equal the slot's. A write that differs in either one opens a separate slot, so each slot is retired on its own.
- R2: A slot stops accepting merges in the cycle its retirement starts. A matching write presented in that cycle or later opens a new slot, which is retired after the first one.
- R3: The oldest occupied slot starts retiring when no write is presented, when every slot is occupied, or when all its bytes are written. Slots are retired one at a time in the order they were opened. While a line read is outstanding, no other lookup, cache write or memory write is issued.
- R4: A slot with wrAlloc=0 is retired as one memory write (mwValid) that carries its line, its security bit and its accumulated byte mask. No cache lookup is made for it.
- R5: A write-allocate slot (wrAlloc=1) that hits in the cache is retired as a cache write with cwAlloc=0 and its accumulated mask. No line read is made.
- R6: A write-allocate slot that misses with every byte written is allocated at once: cwValid=1, cwAlloc=1, full mask, and no line read.
- R7: A write-allocate slot that misses with bytes missing raises rdReqValid for one cycle. At most one line read is outstanding at any time.
- R8: Returned read data fills only the bytes that were never written; written bytes keep the processor's values. The completed line is then allocated with a full mask.
- R9: wrReady is low exactly when every slot is occupied and the presented write cannot merge. A write is accepted on a clock edge where wrValid and wrReady are both high.
- R10: After reset wrReady is high and lkValid, cwValid, mwValid and rdReqValid are all low.

Data layout: byte b of a line is at bits [8b+7:8b] of wrData, rdData and outData, and it is qualified by bit b of wrStrb and outMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write presented |
| wrReady | output | 1 | Write can be taken this cycle |
| wrLine | input | LINE_AW | Line address of the write |
| wrSecure | input | 1 | Security bit of the write |
| wrAlloc | input | 1 | 1 = cacheable write-allocate |
| wrData | input | LINE_BYTES*8 | Write data laid out over the whole line |
| wrStrb | input | LINE_BYTES | Byte strobe of the write |
| lkValid | output | 1 | Cache lookup of outLine/outSecure |
| lkHit | input | 1 | Same-cycle lookup result |
| cwValid | output | 1 | Cache write of outData under outMask |
| cwAlloc | output | 1 | Cache write allocates the line |
| mwValid | output | 1 | Memory write of outData under outMask |
| rdReqValid | output | 1 | Line read request for outLine/outSecure |
| rdDataValid | input | 1 | Read data returned |
| rdData | input | LINE_BYTES*8 | Returned line |
| outLine | output | LINE_AW | Line of the slot being retired |
| outSecure | output | 1 | Security bit of the slot being retired |
| outData | output | LINE_BYTES*8 | Data of the slot being retired |
| outMask | output | LINE_BYTES | Written-byte mask of the slot being retired |

## Verification
The bench builds the block with two slots, four-byte lines and a three-bit line address. This gives sixty-four bytes of backing store across both security bits. At that size a full slot and a full buffer are reached within two or three writes, so merges, the retire-start race and the stall at full occupancy are all driven on purpose. The bench then sweeps every non-zero strobe over every line and security bit, with write-allocate lines and plain lines mixed. At the end it compares every byte of the combined cache and memory image against a reference written in program order.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY,
    SLOT_FILLING,
    SLOT_DRAINING,
    SLOT_WAITFILL
  } slotState_e;

  typedef struct packed {
    logic wrMerge;
    logic wrOpen;
    logic fillLoad;
  } sbStrobe_t;
endpackage

// File: rtl/wmb_datapath.sv
module wmb_datapath
  import wmb_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  sbStrobe_t             strobe,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [IDX_W-1:0]      tailIdx,
  input  logic [LINE_AW-1:0]    wrLine,
  input  logic                  wrSecure,
  input  logic                  wrAlloc,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [LINE_BYTES-1:0] wrStrb,
  input  logic [DATA_W-1:0]     rdData,
  output logic [NUM_SLOTS-1:0]  matchVec,
  output logic [LINE_AW-1:0]    tailLine,
  output logic                  tailSecure,
  output logic                  tailAlloc,
  output logic [DATA_W-1:0]     tailData,
  output logic [LINE_BYTES-1:0] tailMask,
  output logic                  tailFull
);
  logic [LINE_AW-1:0]    slotLine   [NUM_SLOTS];
  logic                  slotSecure [NUM_SLOTS];
  logic                  slotAlloc  [NUM_SLOTS];
  logic [DATA_W-1:0]     slotData   [NUM_SLOTS];
  logic [LINE_BYTES-1:0] slotMask   [NUM_SLOTS];

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++)
      matchVec[s] = (slotLine[s] == wrLine) && (slotSecure[s] == wrSecure);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if ((strobe.wrOpen || strobe.wrMerge) && wrIdx == IDX_W'(s)) begin
        if (strobe.wrOpen) begin
          slotLine[s]   <= wrLine;
          slotSecure[s] <= wrSecure;
          slotAlloc[s]  <= wrAlloc;
        end
        for (int b = 0; b < LINE_BYTES; b++)
          if (wrStrb[b]) slotData[s][8*b +: 8] <= wrData[8*b +: 8];
        slotMask[s] <= strobe.wrOpen ? wrStrb : (slotMask[s] | wrStrb);
      end else if (strobe.fillLoad && tailIdx == IDX_W'(s)) begin
        for (int b = 0; b < LINE_BYTES; b++)
          if (!slotMask[s][b]) slotData[s][8*b +: 8] <= rdData[8*b +: 8];
        slotMask[s] <= '1;
      end
    end
  end

  assign tailLine   = slotLine[tailIdx];
  assign tailSecure = slotSecure[tailIdx];
  assign tailAlloc  = slotAlloc[tailIdx];
  assign tailData   = slotData[tailIdx];
  assign tailMask   = slotMask[tailIdx];
  assign tailFull   = &slotMask[tailIdx];
endmodule

// File: rtl/wmb_control.sv
module wmb_control
  import wmb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [NUM_SLOTS-1:0] matchVec,
  input  logic                 tailAlloc,
  input  logic                 tailFull,
  input  logic                 lkHit,
  input  logic                 rdDataValid,
  output sbStrobe_t            strobe,
  output logic [IDX_W-1:0]     wrIdx,
  output logic [IDX_W-1:0]     tailIdx,
  output logic                 wrReady,
  output logic                 lkValid,
  output logic                 cwValid,
  output logic                 cwAlloc,
  output logic                 mwValid,
  output logic                 rdReqValid
);
  slotState_e          state [NUM_SLOTS];
  logic [IDX_W-1:0]    headPtr, tailPtr, hitIdx;
  logic [CNT_W-1:0]    used;
  logic                bufFull, startDrain, hitAny, accept, drainNow, freeSlot;
  slotState_e          tailState;

  function automatic logic [IDX_W-1:0] stepPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign bufFull    = (used == CNT_W'(NUM_SLOTS));
  assign tailState  = state[tailPtr];
  assign startDrain = (tailState == SLOT_FILLING) && (!wrValid || bufFull || tailFull);

  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (matchVec[s] && state[s] == SLOT_FILLING &&
          !(startDrain && tailPtr == IDX_W'(s))) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(s);
      end
    end
  end

  assign wrReady         = hitAny || !bufFull;
  assign accept          = wrValid && wrReady;
  assign strobe.wrMerge  = accept && hitAny;
  assign strobe.wrOpen   = accept && !hitAny;
  assign strobe.fillLoad = (tailState == SLOT_WAITFILL) && rdDataValid;
  assign wrIdx           = hitAny ? hitIdx : headPtr;
  assign tailIdx         = tailPtr;

  assign drainNow   = (tailState == SLOT_DRAINING);
  assign lkValid    = drainNow && tailAlloc;
  assign mwValid    = drainNow && !tailAlloc;
  assign rdReqValid = lkValid && !lkHit && !tailFull;
  assign cwValid    = lkValid && (lkHit || tailFull);
  assign cwAlloc    = cwValid && !lkHit;
  assign freeSlot   = drainNow && !rdReqValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) state[s] <= SLOT_EMPTY;
      headPtr <= '0;
      tailPtr <= '0;
      used    <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (strobe.wrOpen && headPtr == IDX_W'(s)) begin
          state[s] <= SLOT_FILLING;
        end else if (tailPtr == IDX_W'(s)) begin
          case (state[s])
            SLOT_FILLING:  if (startDrain) state[s] <= SLOT_DRAINING;
            SLOT_DRAINING: state[s] <= freeSlot ? SLOT_EMPTY : SLOT_WAITFILL;
            SLOT_WAITFILL: if (rdDataValid) state[s] <= SLOT_DRAINING;
            default:       state[s] <= state[s];
          endcase
        end
      end
      if (strobe.wrOpen) headPtr <= stepPtr(headPtr);
      if (freeSlot)      tailPtr <= stepPtr(tailPtr);
      used <= used + CNT_W'(strobe.wrOpen) - CNT_W'(freeSlot);
    end
  end
endmodule

// File: rtl/wr_merge_buf.sv
module wr_merge_buf
  import wmb_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  output logic                  wrReady,
  input  logic [LINE_AW-1:0]    wrLine,
  input  logic                  wrSecure,
  input  logic                  wrAlloc,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [LINE_BYTES-1:0] wrStrb,
  output logic                  lkValid,
  input  logic                  lkHit,
  output logic                  cwValid,
  output logic                  cwAlloc,
  output logic                  mwValid,
  output logic                  rdReqValid,
  input  logic                  rdDataValid,
  input  logic [DATA_W-1:0]     rdData,
  output logic [LINE_AW-1:0]    outLine,
  output logic                  outSecure,
  output logic [DATA_W-1:0]     outData,
  output logic [LINE_BYTES-1:0] outMask
);
  sbStrobe_t            strobe;
  logic [IDX_W-1:0]     wrIdx, tailIdx;
  logic [NUM_SLOTS-1:0] matchVec;
  logic                 tailAlloc, tailFull;

  wmb_control #(.NUM_SLOTS(NUM_SLOTS)) ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .matchVec(matchVec),
    .tailAlloc(tailAlloc), .tailFull(tailFull), .lkHit(lkHit),
    .rdDataValid(rdDataValid), .strobe(strobe), .wrIdx(wrIdx),
    .tailIdx(tailIdx), .wrReady(wrReady), .lkValid(lkValid),
    .cwValid(cwValid), .cwAlloc(cwAlloc), .mwValid(mwValid),
    .rdReqValid(rdReqValid)
  );

  wmb_datapath #(.NUM_SLOTS(NUM_SLOTS), .LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)) dp (
    .clk(clk), .strobe(strobe), .wrIdx(wrIdx), .tailIdx(tailIdx),
    .wrLine(wrLine), .wrSecure(wrSecure), .wrAlloc(wrAlloc),
    .wrData(wrData), .wrStrb(wrStrb), .rdData(rdData),
    .matchVec(matchVec), .tailLine(outLine), .tailSecure(outSecure),
    .tailAlloc(tailAlloc), .tailData(outData), .tailMask(outMask),
    .tailFull(tailFull)
  );
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
  parameter int LINE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  lkValid,
  input logic                  cwValid,
  input logic                  cwAlloc,
  input logic                  mwValid,
  input logic                  rdReqValid,
  input logic                  rdDataValid,
  input logic [LINE_BYTES-1:0] outMask
);
  logic fillPending;

  always_ff @(posedge clk) begin
    if (!rstN)            fillPending <= 1'b0;
    else if (rdReqValid)  fillPending <= 1'b1;
    else if (rdDataValid) fillPending <= 1'b0;
  end

  // R6
  alloc_full_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cwValid && cwAlloc) |-> &outMask);

  // R7
  fill_partial_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid |-> !(&outMask));

  // R7
  single_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid |-> !fillPending);

  // R3
  fill_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillPending |-> !(lkValid || cwValid || mwValid || rdReqValid));

  // R3
  drain_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cwValid, mwValid, rdReqValid}));
endmodule

bind wr_merge_buf wmb_checker #(.LINE_BYTES(LINE_BYTES)) chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .cwValid(cwValid),
  .cwAlloc(cwAlloc), .mwValid(mwValid), .rdReqValid(rdReqValid),
  .rdDataValid(rdDataValid), .outMask(outMask)
);

// File: tb/wr_merge_buf_test.sv
module wr_merge_buf_test;
  localparam int NS = 2;
  localparam int NB = 4;
  localparam int LA = 3;
  localparam int NLINES = 1 << LA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrSecure = 1'b0, wrAlloc = 1'b0;
  logic [LA-1:0] wrLine = '0;
  logic [NB*8-1:0] wrData = '0;
  logic [NB-1:0] wrStrb = '0;
  logic lkHit = 1'b0, rdDataValid = 1'b0;
  logic [NB*8-1:0] rdData = '0;
  logic wrReady, lkValid, cwValid, cwAlloc, mwValid, rdReqValid, outSecure;
  logic [LA-1:0] outLine;
  logic [NB*8-1:0] outData;
  logic [NB-1:0] outMask;

  always #10 clk = ~clk;

  wr_merge_buf #(.NUM_SLOTS(NS), .LINE_BYTES(NB), .LINE_AW(LA)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrLine(wrLine), .wrSecure(wrSecure), .wrAlloc(wrAlloc),
    .wrData(wrData), .wrStrb(wrStrb), .lkValid(lkValid), .lkHit(lkHit),
    .cwValid(cwValid), .cwAlloc(cwAlloc), .mwValid(mwValid),
    .rdReqValid(rdReqValid), .rdDataValid(rdDataValid), .rdData(rdData),
    .outLine(outLine), .outSecure(outSecure), .outData(outData),
    .outMask(outMask)
  );

  logic [7:0] memB [64];
  logic [7:0] cacheB [64];
  logic [7:0] expB [64];
  logic       present [16];
  int nChecks = 0, nFails = 0;
  int mwN = 0, lkN = 0, rdN = 0, fillCnt = 0, fillIdx = 0;
  int logLine [16], logSec [16], logMask [16];
  int lastCwAlloc = -1, lastCwMask = -1;

  function automatic int bIdx(input int sec, input int line, input int b);
    return sec * 32 + line * 4 + b;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // backend models: cache, memory, line reads
  always @(negedge clk) begin
    rdDataValid = 1'b0;
    if (fillCnt != 0) begin
      fillCnt--;
      if (fillCnt == 0) begin
        rdDataValid = 1'b1;
        for (int b = 0; b < NB; b++) rdData[8*b +: 8] = memB[fillIdx + b];
      end
    end
    lkHit = lkValid && present[int'(outSecure) * 8 + int'(outLine)];
    #1;
    if (rstN) begin
      if (lkValid) lkN++;
      if (cwValid) begin
        for (int b = 0; b < NB; b++)
          if (outMask[b]) cacheB[bIdx(outSecure, outLine, b)] = outData[8*b +: 8];
        if (cwAlloc) present[int'(outSecure) * 8 + int'(outLine)] = 1'b1;
        lastCwAlloc = int'(cwAlloc);
        lastCwMask = int'(outMask);
      end
      if (mwValid) begin
        for (int b = 0; b < NB; b++)
          if (outMask[b]) memB[bIdx(outSecure, outLine, b)] = outData[8*b +: 8];
        if (mwN < 16) begin
          logLine[mwN] = int'(outLine);
          logSec[mwN] = int'(outSecure);
          logMask[mwN] = int'(outMask);
        end
        mwN++;
      end
      if (rdReqValid) begin
        check("R7 one read outstanding", fillCnt, 0);
        rdN++;
        fillCnt = 3;
        fillIdx = bIdx(outSecure, outLine, 0);
      end
    end
  end

  task automatic putWrite(input int line, input bit sec, input bit alloc,
                          input logic [NB-1:0] strb, input logic [NB*8-1:0] data,
                          output int stalls);
    @(negedge clk);
    wrValid = 1'b1; wrLine = LA'(line); wrSecure = sec; wrAlloc = alloc;
    wrStrb = strb; wrData = data;
    #1;
    stalls = 0;
    while (!wrReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    for (int b = 0; b < NB; b++)
      if (strb[b]) expB[bIdx(sec, line, b)] = data[8*b +: 8];
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wrValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int st, st2, st3;
    for (int i = 0; i < 64; i++) begin
      memB[i] = 8'(i * 13 + 5) ^ 8'h5A;
      cacheB[i] = memB[i];
      expB[i] = memB[i];
    end
    for (int i = 0; i < 16; i++) present[i] = 1'b0;
    present[6] = 1'b1; // secure 0, line 6 starts resident
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R10 reset state
    check("R10 wrReady", wrReady, 1);
    check("R10 outputs idle", {lkValid, cwValid, mwValid, rdReqValid}, 0);

    // R1 merge of same line and security
    putWrite(1, 0, 0, 4'b0001, 32'h000000A1, st);
    putWrite(1, 0, 0, 4'b0010, 32'h0000B200, st);
    idle(8);
    check("R1 merged count", mwN, 1);
    check("R1 merged mask", logMask[0], 3);
    check("R1 merged line", logLine[0], 1);

    // R1 differing security bit opens a second slot
    mwN = 0;
    putWrite(2, 0, 0, 4'b0100, 32'h00C30000, st);
    putWrite(2, 1, 0, 4'b0100, 32'h00C40000, st);
    idle(8);
    check("R1 split count", mwN, 2);
    check("R1 split sec order", logSec[0] * 2 + logSec[1], 1);

    // R2 write racing a slot that starts retiring
    mwN = 0;
    putWrite(3, 0, 0, 4'b1111, 32'h11223344, st);
    putWrite(3, 0, 0, 4'b0001, 32'h00000055, st);
    idle(8);
    check("R2 race count", mwN, 2);
    check("R2 first mask", logMask[0], 15);
    check("R2 second mask", logMask[1], 1);

    // R9 backpressure with both slots taken, R3 order
    mwN = 0;
    putWrite(0, 1, 0, 4'b1000, 32'h61000000, st);
    putWrite(1, 1, 0, 4'b1000, 32'h62000000, st2);
    putWrite(2, 1, 0, 4'b0001, 32'h00000063, st3);
    idle(10);
    check("R9 no stall with free slot", st2, 0);
    check("R9 stall cycles when full", st3, 2);
    check("R3 drain order", logLine[0] * 16 + logLine[1] * 4 + logLine[2], 6);
    // R4 no lookups for plain slots
    check("R4 no lookup", lkN, 0);
    check("R4 write count", mwN, 3);

    // R5 hit in cache
    putWrite(6, 0, 1, 4'b0011, 32'h0000E1E2, st);
    idle(8);
    check("R5 hit not allocating", lastCwAlloc, 0);
    check("R5 hit mask", lastCwMask, 3);
    check("R5 no read", rdN, 0);
    check("R5 no memory write", mwN, 3);

    // R6 miss with full line
    putWrite(5, 0, 1, 4'b1111, 32'h71727374, st);
    idle(8);
    check("R6 allocating", lastCwAlloc, 1);
    check("R6 full mask", lastCwMask, 15);
    check("R6 no read", rdN, 0);

    // R7 and R8 miss with gaps
    putWrite(4, 1, 1, 4'b0101, 32'hDDCCBBAA, st);
    idle(12);
    check("R7 one read", rdN, 1);
    check("R8 allocating", lastCwAlloc, 1);
    check("R8 full mask", lastCwMask, 15);
    check("R8 written byte 0", cacheB[bIdx(1, 4, 0)], 8'hAA);
    check("R8 filled byte 1", cacheB[bIdx(1, 4, 1)], 8'(bIdx(1, 4, 1) * 13 + 5) ^ 8'h5A);
    check("R8 written byte 2", cacheB[bIdx(1, 4, 2)], 8'hCC);
    check("R8 filled byte 3", cacheB[bIdx(1, 4, 3)], 8'(bIdx(1, 4, 3) * 13 + 5) ^ 8'h5A);

    // sweep: every strobe over every line and security bit
    for (int s = 1; s < 16; s++) begin
      for (int sec = 0; sec < 2; sec++) begin
        for (int ln = 0; ln < NLINES; ln++) begin
          logic [NB*8-1:0] d;
          for (int b = 0; b < NB; b++) d[8*b +: 8] = 8'(s * 16 + ln * 2 + sec + b * 37);
          putWrite(ln, sec[0], ln >= 4, 4'(s), d, st);
          if ((s + ln + sec) % 3 == 0) idle(1);
        end
      end
    end
    idle(30);
    for (int sec = 0; sec < 2; sec++) begin
      for (int ln = 0; ln < NLINES; ln++) begin
        for (int b = 0; b < NB; b++) begin
          int k;
          logic [7:0] eff;
          k = bIdx(sec, ln, b);
          eff = (ln >= 4 && present[sec * 8 + ln]) ? cacheB[k] : memB[k];
          if (ln >= 4) check("R8 final image", eff, expB[k]);
          else         check("R4 final image", eff, expB[k]);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule